// File: doc/BRIEF.md
# Serial Control Register Port

This block takes 16-bit control words from a three-wire serial link (a shift clock, an enable and a shared data line) and writes each complete word into one of a small set of addressed configuration registers. The serial lines are brought into the system clock domain through synchronizers. Data bits are taken on each falling shift-clock edge, least significant bit first. A word is committed only when the enable window holds at least sixteen such edges. The block then pulls the data line low as an acknowledge.

Each word carries a 3-bit register address in its low bits and a 13-bit payload above it. Five registers are implemented. Register 4 holds the 2-bit sleep field. Whenever that field selects a deep sleep state, every other control field is forced back to its default, and the sleep field itself keeps its value. A word that leaves deep sleep still writes its other bits. All register contents are presented in parallel on one flat output bus.

Top module: `sctl_port`

## Requirements
- R1: After reset every register holds its default: register 2 reads 13'h0003 (a 3-bit coefficient code of 011 in bits [2:0]), all other registers read zero, and the acknowledge pull is released.
- R2: While enable is high, each falling shift-clock edge takes one data bit, least significant bit first. Word bits [2:0] are the address and bits [15:3] are the payload written to the addressed register.
- R3: An enable window with fewer than sixteen falling edges changes no register and never asserts the acknowledge.
- R4: In a window with more than sixteen falling edges, the first sixteen bits form the word and any later edges and bits have no effect.
- R5: The acknowledge pull is asserted after the sixteenth falling edge and stays asserted while enable is high. It is released once enable is low.
- R6: Addresses 0 to 4 update only the addressed register. Addresses 5 to 7 update no register but still produce the acknowledge.
- R7: While the sleep field (register 4 bits [1:0]) has bit 1 set, every other bit of every register is held at its default and the sleep field keeps its written value.
- R8: A word to register 4 that clears sleep bit 1 also stores its other payload bits, and later writes to other registers take effect again.
- R9: The bit count restarts whenever enable goes low, so two partial windows never combine into one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the shift-clock rate |
| rst | input | 1 | Synchronous active-high reset (power-up preset) |
| sclk_i | input | 1 | Serial shift clock |
| senb_i | input | 1 | Serial enable, a window is open while high |
| sdata_i | input | 1 | Level seen on the shared serial data line |
| sdata_pull_o | output | 1 | Open-drain acknowledge drive: 1 pulls the data line low |
| cfg_o | output | 65 | Register contents, register p in bits [13p+12:13p] |

## Verification
The bench uses the default build: a 16-bit word, a 3-bit address, five registers and two synchronizer stages. With this build the address space has three unused codes, so the ignored-address path can be reached. A behavioural model tracks the synchronizer delay, the edge count and the register contents on every clock. Short, long and split windows are driven, along with entry into and exit from deep sleep, so that the count limits and the preset precedence are each exercised at their boundaries.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    parameter int WORD_W     = 16;
    parameter int ADDR_W     = 3;
    parameter int NPORT      = 5;
    parameter int SYNC_DEPTH = 2;
    parameter int SLEEP_PORT = 4;
    parameter int SLEEP_LSB  = 0;
    parameter int CG_PORT    = 2;

    localparam int DW    = WORD_W - ADDR_W;
    localparam int CNT_W = $clog2(WORD_W + 1);

    typedef logic [DW-1:0] field_t;

    typedef struct packed {
        field_t              data;
        logic [ADDR_W-1:0]   addr;
    } word_t;

    typedef enum logic [1:0] {
        SLP_RUN  = 2'b00,
        SLP_LITE = 2'b01,
        SLP_DEEP = 2'b10,
        SLP_ALL  = 2'b11
    } sleep_e;

    function automatic field_t port_default(input int p);
        field_t v;
        v = '0;
        if (p == CG_PORT) v[2:0] = 3'b011;
        return v;
    endfunction

    function automatic field_t keep_mask(input int p);
        field_t m;
        m = '0;
        if (p == SLEEP_PORT) m[SLEEP_LSB +: 2] = 2'b11;
        return m;
    endfunction

    function automatic logic is_deep(input logic [1:0] s);
        return (s == SLP_DEEP) || (s == SLP_ALL);
    endfunction
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/sctl_rx.sv
module sctl_rx
    import sctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_s,
    input  logic             senb_s,
    input  logic             sdata_s,
    output logic             wr_en,
    output word_t            wr_word,
    output logic             ack,
    output logic [CNT_W-1:0] bit_cnt
);
    logic              sclk_prev;
    logic [WORD_W-1:0] shreg;
    logic              fall;
    logic              take;

    assign fall = sclk_prev & ~sclk_s;
    assign take = fall & senb_s & (bit_cnt < CNT_W'(WORD_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            shreg     <= '0;
            bit_cnt   <= '0;
            ack       <= 1'b0;
        end else begin
            sclk_prev <= sclk_s;
            if (!senb_s) begin
                bit_cnt <= '0;
                ack     <= 1'b0;
            end else if (take) begin
                shreg[bit_cnt[CNT_W-2:0]] <= sdata_s;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(WORD_W - 1)) ack <= 1'b1;
            end
        end
    end

    always_comb begin
        wr_word = word_t'(shreg);
        wr_word[WORD_W-1] = sdata_s;
        wr_en = take && (bit_cnt == CNT_W'(WORD_W - 1));
    end
endmodule

// File: rtl/sctl_regbank.sv
module sctl_regbank
    import sctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  word_t               wr_word,
    output logic [NPORT*DW-1:0] cfg
);
    field_t regs [NPORT];
    field_t nxt  [NPORT];
    logic   deep;

    always_comb begin
        for (int p = 0; p < NPORT; p++) nxt[p] = regs[p];
        if (wr_en && (int'(wr_word.addr) < NPORT))
            nxt[wr_word.addr] = wr_word.data;
        deep = is_deep(nxt[SLEEP_PORT][SLEEP_LSB +: 2]);
        if (deep) begin
            for (int p = 0; p < NPORT; p++)
                nxt[p] = (nxt[p] & keep_mask(p)) | (port_default(p) & ~keep_mask(p));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPORT; p++) regs[p] <= port_default(p);
        end else begin
            for (int p = 0; p < NPORT; p++) regs[p] <= nxt[p];
        end
    end

    genvar g;
    generate
        for (g = 0; g < NPORT; g++) begin : g_out
            assign cfg[g*DW +: DW] = regs[g];
        end
    endgenerate
endmodule

// File: rtl/sctl_port.sv
module sctl_port
    import sctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk_i,
    input  logic                senb_i,
    input  logic                sdata_i,
    output logic                sdata_pull_o,
    output logic [NPORT*DW-1:0] cfg_o
);
    logic             sclk_s, senb_s, sdata_s;
    logic             wr_en;
    word_t            wr_word;
    logic [CNT_W-1:0] bit_cnt;

    sctl_sync #(.W(3), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk_i, senb_i, sdata_i}),
        .q   ({sclk_s, senb_s, sdata_s})
    );

    sctl_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (sclk_s),
        .senb_s  (senb_s),
        .sdata_s (sdata_s),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .ack     (sdata_pull_o),
        .bit_cnt (bit_cnt)
    );

    sctl_regbank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .cfg     (cfg_o)
    );
endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk
    import sctl_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                senb_s,
    input logic                ack,
    input logic [CNT_W-1:0]    bit_cnt,
    input logic [NPORT*DW-1:0] cfg
);
    logic [NPORT*DW-1:0] prev;
    logic                prev_ok;
    logic [NPORT-1:0]    changed;
    logic                deep_now;
    logic                preset_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= '0;
            prev_ok <= 1'b0;
        end else begin
            prev    <= cfg;
            prev_ok <= 1'b1;
        end
    end

    always_comb begin
        deep_now  = is_deep(cfg[SLEEP_PORT*DW + SLEEP_LSB +: 2]);
        preset_ok = 1'b1;
        for (int p = 0; p < NPORT; p++) begin
            changed[p] = prev[p*DW +: DW] != cfg[p*DW +: DW];
            if (((cfg[p*DW +: DW] ^ port_default(p)) & ~keep_mask(p)) != '0)
                preset_ok = 1'b0;
        end
    end

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !senb_s |=> !ack); // R5
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ack && senb_s) |=> ack); // R5
    AST_ACK_FULL_WORD: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> (bit_cnt == CNT_W'(WORD_W))); // R3
    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(WORD_W)); // R4
    AST_DEEP_PRESET: assert property (@(posedge clk) disable iff (rst)
        deep_now |-> preset_ok); // R7
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
        (prev_ok && !deep_now && !is_deep(prev[SLEEP_PORT*DW + SLEEP_LSB +: 2]))
        |-> $countones(changed) <= 1); // R6
endmodule

bind sctl_port sctl_port_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .senb_s  (senb_s),
    .ack     (sdata_pull_o),
    .bit_cnt (bit_cnt),
    .cfg     (cfg_o)
);

// File: tb/test_sctl_port.sv
module test_sctl_port;
    import sctl_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                sclk = 1'b0;
    logic                senb = 1'b0;
    logic                drv  = 1'b1;
    logic                wire_sd;
    logic                pull;
    logic [NPORT*DW-1:0] cfg;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    logic ack_seen;

    assign wire_sd = pull ? 1'b0 : drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    sctl_port i_sctl_port (
        .clk          (clk),
        .rst          (rst),
        .sclk_i       (sclk),
        .senb_i       (senb),
        .sdata_i      (wire_sd),
        .sdata_pull_o (pull),
        .cfg_o        (cfg)
    );

    // behavioural reference model
    logic [12:0] mreg [5];
    logic [15:0] mword;
    int          mcnt;
    logic        mack;
    logic [2:0]  h1, h2, h3, cur;

    task automatic model_reset();
        for (int p = 0; p < 5; p++) mreg[p] = 13'h0;
        mreg[2] = 13'h0003;
        mword = '0; mcnt = 0; mack = 1'b0;
        h1 = '0; h2 = '0; h3 = '0;
    endtask

    always @(negedge clk) cur = {sclk, senb, wire_sd};

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            if (!h2[1]) begin
                mcnt = 0; mack = 1'b0;
            end else if (h3[2] && !h2[2] && mcnt < 16) begin
                mword[mcnt] = h2[0];
                mcnt++;
                if (mcnt == 16) begin
                    mack = 1'b1;
                    if (mword[2:0] < 3'd5) mreg[mword[2:0]] = mword[15:3];
                    if (mreg[4][1]) begin
                        for (int p = 0; p < 4; p++) mreg[p] = 13'h0;
                        mreg[2] = 13'h0003;
                        mreg[4] = {11'h0, mreg[4][1:0]};
                    end
                end
            end
            h3 = h2; h2 = h1; h1 = cur;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            checks++;
            if (pull !== mack) begin
                failures++;
                $display("FAIL R5 cycle %0d ack actual=%b expected=%b", cycles, pull, mack);
            end
            for (int p = 0; p < 5; p++) begin
                checks++;
                if (cfg[p*13 +: 13] !== mreg[p]) begin
                    failures++;
                    $display("FAIL R2 cycle %0d reg%0d actual=%h expected=%h",
                             cycles, p, cfg[p*13 +: 13], mreg[p]);
                end
            end
        end
        if (pull) ack_seen = 1'b1;
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic check_reg(input int p, input logic [12:0] exp, input string tag);
        #1;
        checks++;
        if (cfg[p*13 +: 13] !== exp) begin
            failures++;
            $display("FAIL %s reg%0d actual=%h expected=%h", tag, p, cfg[p*13 +: 13], exp);
        end
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // one enable window carrying nbits bits; bits beyond 16 are ones
    task automatic send(input logic [15:0] w, input int nbits, input logic close);
        ack_seen = 1'b0;
        senb = 1'b1;
        wait_clk(2);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1;
            drv  = (i < 16) ? w[i] : 1'b1;
            wait_clk(HALF_SCK);
            sclk = 1'b0;
            wait_clk(HALF_SCK);
        end
        wait_clk(4);
        if (close) begin
            senb = 1'b0;
            drv  = 1'b1;
            wait_clk(6);
        end
    endtask

    function automatic logic [15:0] mk(input logic [12:0] d, input logic [2:0] a);
        return {d, a};
    endfunction

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        // R1 reset state
        check_reg(0, 13'h0000, "R1");
        check_reg(2, 13'h0003, "R1");
        check_reg(4, 13'h0000, "R1");
        check_bit(pull, 1'b0, "R1 ack");

        // R2 plain write, R5 ack while enable high then released
        send(mk(13'h1ABC, 3'd0), 16, 1'b0);
        check_bit(pull, 1'b1, "R5 ack held");
        senb = 1'b0; wait_clk(6);
        check_bit(pull, 1'b0, "R5 ack released");
        check_reg(0, 13'h1ABC, "R2");
        check_reg(1, 13'h0000, "R6 neighbour");

        // R3 short window
        send(mk(13'h0F0F, 3'd1), 10, 1'b1);
        check_bit(ack_seen, 1'b0, "R3 no ack");
        check_reg(1, 13'h0000, "R3");

        // R4 long window
        send(mk(13'h0555, 3'd1), 19, 1'b1);
        check_bit(ack_seen, 1'b1, "R4 ack");
        check_reg(1, 13'h0555, "R4");

        // R6 unused address
        send(mk(13'h1FFF, 3'd6), 16, 1'b1);
        check_bit(ack_seen, 1'b1, "R6 ack");
        check_reg(0, 13'h1ABC, "R6");
        check_reg(1, 13'h0555, "R6");
        check_reg(3, 13'h0000, "R6");

        // R9 split window
        send(mk(13'h1234, 3'd3), 10, 1'b1);
        send(mk(13'h1234, 3'd3), 10, 1'b1);
        check_reg(3, 13'h0000, "R9");

        // R7 deep sleep preset
        send(mk(13'h0015, 3'd2), 16, 1'b1);
        check_reg(2, 13'h0015, "R2 reg2");
        send(mk(13'h0102, 3'd4), 16, 1'b1);
        check_reg(4, 13'h0002, "R7 sleep kept");
        check_reg(0, 13'h0000, "R7");
        check_reg(2, 13'h0003, "R7");
        send(mk(13'h0777, 3'd0), 16, 1'b1);
        check_reg(0, 13'h0000, "R7 write blocked");

        // R8 leave sleep with payload
        send(mk(13'h0155, 3'd4), 16, 1'b1);
        check_reg(4, 13'h0155, "R8");
        send(mk(13'h0777, 3'd0), 16, 1'b1);
        check_reg(0, 13'h0777, "R8");

        // R1 preset again
        rst = 1'b1; wait_clk(2); rst = 1'b0; wait_clk(1);
        check_reg(0, 13'h0000, "R1 again");
        check_reg(4, 13'h0000, "R1 again");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule